// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence Filter

This block watches the stream of 16-bit light-sensor results and decides when the host should be interrupted. Each result arrives with a one-cycle valid strobe. The block compares it against a window. The window's upper and lower edges are set by two 8-bit threshold bytes. Each byte supplies the high byte of a 16-bit bound, and the low byte is implied to be zero. A result that falls outside the window counts toward a persistence target. The target is picked by a 2-bit field and is 1, 4, 8 or 16 consecutive results. When the target is reached, a sticky interrupt flag is raised. The flag also drives the enable of an open-drain pull-down on the interrupt pin, so the pin goes low while the flag is set.

The flag stays set until the host pulses the clear input. A clear also restarts the consecutive count. Any result that lies inside the window resets the count, so isolated spikes such as a camera flash never raise the interrupt when a longer persistence target is chosen. The two threshold bytes are held in local registers. These registers are loaded by write strobes and start from the widest possible window.

Top module: `lux_window_alarm`

## Requirements
- R1: After reset the upper threshold byte is 0xFF and the lower byte is 0x00, and with these values no 16-bit result is outside the window, including 0x0000 and 0xFFFF. After reset irq_flag and irq_pull_en are 0.
- R2: A cycle with thr_hi_wr high loads thr_wdata into the upper threshold byte, and a cycle with thr_lo_wr high loads it into the lower byte. The new value applies to every result sampled on a later clock edge.
- R3: Take H and L as the threshold bytes read as unsigned numbers. A valid result D is outside the window when D >= (H+1)*256 or D < L*256, and inside otherwise.
- R4: persist_sel selects the number of consecutive outside results needed to trigger: 0 means 1, 1 means 4, 2 means 8, and 3 means 16.
- R5: A valid result inside the window resets the consecutive count to zero.
- R6: Cycles with res_valid low neither advance nor reset the count, whatever value res_data holds.
- R7: A triggering result sampled at clock edge k makes irq_flag read 1 after edge k+1.
- R8: Once set, irq_flag stays 1 through any later results, inside or outside the window, until a clear pulse arrives.
- R9: A clr_pulse sampled at an edge clears irq_flag at that edge. If a trigger occurs at the same edge, the flag remains set.
- R10: A clear pulse resets the consecutive count to zero, so the full persistence target must be met again afterwards.
- R11: irq_pull_en always equals irq_flag. A value of 1 means the interrupt pin is pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe that marks a new sensor result |
| res_data | input | 16 | Sensor result, unsigned |
| thr_hi_wr | input | 1 | Load strobe for the upper threshold byte |
| thr_lo_wr | input | 1 | Load strobe for the lower threshold byte |
| thr_wdata | input | 8 | Threshold byte value to load |
| persist_sel | input | 2 | Persistence target select (1, 4, 8 or 16) |
| clr_pulse | input | 1 | Host interrupt-clear command |
| irq_flag | output | 1 | Sticky interrupt flag, 1 when triggered |
| irq_pull_en | output | 1 | Pull-down enable for the active-low open-drain pin |

## Verification
The assertions assume that res_valid is a single-cycle strobe per integration result. They also assume that persist_sel holds steady while a count is in progress and that clear pulses last one cycle. The bench drives every result as an isolated one-cycle strobe between idle cycles. It changes persist_sel and the thresholds only after a clear has emptied the count. It pulses the clear for exactly one cycle. The window sweep runs over all 256 high bytes under four threshold pairs. Those pairs include the reset pair, an inverted pair and an equal pair. A single-step target is used for the sweep, so each result's effect is seen on its own.

// File: rtl/win_irq_pkg.sv
package win_irq_pkg;

  localparam int unsigned PERSIST_MAX = 16;
  localparam int unsigned CNT_W       = $clog2(PERSIST_MAX + 1);

  typedef struct packed {
    logic vld;
    logic above;
    logic below;
  } cmp_res_t;

  function automatic logic [CNT_W-1:0] persist_target(input logic [1:0] sel);
    logic [CNT_W-1:0] t;
    case (sel)
      2'd0:    t = CNT_W'(1);
      2'd1:    t = CNT_W'(4);
      2'd2:    t = CNT_W'(8);
      default: t = CNT_W'(PERSIST_MAX);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/win_thr_regs.sv
module win_thr_regs #(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hi_wr,
  input  logic             lo_wr,
  input  logic [THR_W-1:0] wdata,
  output logic [THR_W-1:0] hi_q,
  output logic [THR_W-1:0] lo_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '1;
      lo_q <= '0;
    end else begin
      if (hi_wr) hi_q <= wdata;
      if (lo_wr) lo_q <= wdata;
    end
  end

  // R2
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> $stable(hi_q));
  // R2
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lo_wr |=> $stable(lo_q));

endmodule

// File: rtl/win_cmp.sv
module win_cmp
  import win_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [THR_W-1:0]  thr_hi,
  input  logic [THR_W-1:0]  thr_lo,
  output cmp_res_t          res_q
);

  localparam int unsigned LOW_W = DATA_W - THR_W;

  logic [DATA_W:0] upper_lim;
  logic [DATA_W:0] lower_lim;
  logic            is_above;
  logic            is_below;

  always_comb begin
    upper_lim = {1'b0, thr_hi, {LOW_W{1'b0}}} + (DATA_W + 1)'(1 << LOW_W);
    lower_lim = {1'b0, thr_lo, {LOW_W{1'b0}}};
    is_above  = {1'b0, in_data} >= upper_lim;
    is_below  = {1'b0, in_data} <  lower_lim;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else begin
      res_q.vld   <= in_vld;
      res_q.above <= in_vld & is_above;
      res_q.below <= in_vld & is_below;
    end
  end

  // R6
  vld_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_q.vld);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !res_q.vld && !res_q.above && !res_q.below);

endmodule

// File: rtl/win_persist.sv
module win_persist
  import win_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmp_res_t   cmp_in,
  input  logic [1:0] sel,
  input  logic       clr,
  output logic       trig
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic [CNT_W:0]   nxt_sum;
  logic             reached;
  logic             oow;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    target  = persist_target(sel);
    oow     = cmp_in.vld & (cmp_in.above | cmp_in.below);
    nxt_sum = {1'b0, cnt_q} + (CNT_W + 1)'(1);
    reached = nxt_sum >= {1'b0, target};
    cnt_inc = reached ? target : nxt_sum[CNT_W-1:0];
    trig    = oow & reached;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (cmp_in.vld) begin
      cnt_q <= oow ? cnt_inc : '0;
    end
  end

  // R6
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_in.vld && !clr |=> $stable(cnt_q));
  // R5
  cnt_inwin_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_in.vld && !cmp_in.above && !cmp_in.below && !clr |=> cnt_q == '0);
  // R10
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0);
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(PERSIST_MAX));

endmodule

// File: rtl/lux_window_alarm.sv
module lux_window_alarm
  import win_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              thr_hi_wr,
  input  logic              thr_lo_wr,
  input  logic [THR_W-1:0]  thr_wdata,
  input  logic [1:0]        persist_sel,
  input  logic              clr_pulse,
  output logic              irq_flag,
  output logic              irq_pull_en
);

  logic [THR_W-1:0] hi_q;
  logic [THR_W-1:0] lo_q;
  cmp_res_t         cmp_q;
  logic             trig;
  logic             flag_q;
  logic             pull_q;

  win_thr_regs #(.THR_W(THR_W)) u_thr (
    .clk   (clk),
    .rst   (rst),
    .hi_wr (thr_hi_wr),
    .lo_wr (thr_lo_wr),
    .wdata (thr_wdata),
    .hi_q  (hi_q),
    .lo_q  (lo_q)
  );

  win_cmp #(.DATA_W(DATA_W), .THR_W(THR_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (res_valid),
    .in_data (res_data),
    .thr_hi  (hi_q),
    .thr_lo  (lo_q),
    .res_q   (cmp_q)
  );

  win_persist u_persist (
    .clk    (clk),
    .rst    (rst),
    .cmp_in (cmp_q),
    .sel    (persist_sel),
    .clr    (clr_pulse),
    .trig   (trig)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      pull_q <= 1'b0;
    end else if (trig) begin
      flag_q <= 1'b1;
      pull_q <= 1'b1;
    end else if (clr_pulse) begin
      flag_q <= 1'b0;
      pull_q <= 1'b0;
    end
  end

  assign irq_flag    = flag_q;
  assign irq_pull_en = pull_q;

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq_flag && !clr_pulse |=> irq_flag);
  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_pulse && !trig |=> !irq_flag);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_pulse && trig |=> irq_flag);
  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(cmp_q.vld));
  // R11
  pull_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pull_en == irq_flag);

endmodule

// File: tb/tb_lux_window_alarm.sv
module tb_lux_window_alarm;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        thr_hi_wr = 1'b0;
  logic        thr_lo_wr = 1'b0;
  logic [7:0]  thr_wdata = '0;
  logic [1:0]  persist_sel = '0;
  logic        clr_pulse = 1'b0;
  logic        irq_flag;
  logic        irq_pull_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lux_window_alarm dut (
    .clk         (clk),
    .rst         (rst),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .thr_hi_wr   (thr_hi_wr),
    .thr_lo_wr   (thr_lo_wr),
    .thr_wdata   (thr_wdata),
    .persist_sel (persist_sel),
    .clr_pulse   (clr_pulse),
    .irq_flag    (irq_flag),
    .irq_pull_en (irq_pull_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one valid strobe; returns at the negedge after its sampling edge
  task automatic put(input logic [15:0] d);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_pulse = 1'b1;
    @(negedge clk);
    clr_pulse = 1'b0;
  endtask

  task automatic set_thr(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    thr_hi_wr = 1'b1;
    thr_wdata = hi;
    @(negedge clk);
    thr_hi_wr = 1'b0;
    thr_lo_wr = 1'b1;
    thr_wdata = lo;
    @(negedge clk);
    thr_lo_wr = 1'b0;
  endtask

  function automatic logic outside(input int d, input int hi, input int lo);
    return (d >= (hi + 1) * 256) || (d < lo * 256);
  endfunction

  function automatic int target_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 16;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7: watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int hi_tab[4];
    int lo_tab[4];
    hi_tab = '{8'hFF, 8'h80, 8'h10, 8'h00};
    lo_tab = '{8'h00, 8'h40, 8'h10, 8'hFF};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 / R11 reset state
    chk("R1 flag after reset", irq_flag, 1'b0);
    chk("R11 pull after reset", irq_pull_en, 1'b0);

    // R1: default window contains every value
    persist_sel = 2'd0;
    put(16'h0000); settle();
    chk("R1 0x0000 in default window", irq_flag, 1'b0);
    put(16'hFFFF); settle();
    chk("R1 0xFFFF in default window", irq_flag, 1'b0);
    put(16'hFF00); settle();
    chk("R1 0xFF00 in default window", irq_flag, 1'b0);

    // R2 / R3 sweep over all high bytes for several threshold pairs
    for (int p = 0; p < 4; p++) begin
      set_thr(hi_tab[p][7:0], lo_tab[p][7:0]);
      do_clear();
      for (int hb = 0; hb < 256; hb++) begin
        int d;
        logic e;
        d = hb * 256 + ((hb * 37 + p * 91) % 256);
        e = outside(d, hi_tab[p], lo_tab[p]);
        put(16'(d)); settle();
        chk("R3 window sweep", irq_flag, e);
        chk("R11 pull follows flag", irq_pull_en, e);
        if (e) do_clear();
      end
    end

    // R4 / R5 persistence targets
    set_thr(8'h80, 8'h40);
    for (int s = 0; s < 4; s++) begin
      int t;
      t = target_of(s);
      persist_sel = 2'(s);
      do_clear();
      for (int i = 0; i < t - 1; i++) put(16'h9000);
      settle();
      chk("R4 one short of target", irq_flag, 1'b0);
      put(16'h2000); settle();
      chk("R4 target reached", irq_flag, 1'b1);
      do_clear();
      chk("R9 clear drops flag", irq_flag, 1'b0);
      for (int i = 0; i < t - 1; i++) put(16'h9000);
      put(16'h6000);
      for (int i = 0; i < t - 1; i++) put(16'hC000);
      settle();
      chk("R5 in-window result resets count", irq_flag, 1'b0);
      put(16'h0100); settle();
      chk("R5 target met after reset", irq_flag, 1'b1);
      do_clear();
    end

    // R6: invalid cycles neither advance nor reset
    persist_sel = 2'd1;
    do_clear();
    for (int i = 0; i < 3; i++) put(16'h9000);
    @(negedge clk); res_data = 16'h6000;
    @(negedge clk); res_data = 16'hF000;
    @(negedge clk); res_data = 16'h5000;
    repeat (3) settle();
    chk("R6 invalid cycles ignored (no trigger)", irq_flag, 1'b0);
    put(16'h9000); settle();
    chk("R6 count kept across invalid cycles", irq_flag, 1'b1);

    // R8: sticky through later results
    for (int i = 0; i < 5; i++) begin
      put(16'h6000); settle();
      chk("R8 flag sticky on in-window result", irq_flag, 1'b1);
    end
    put(16'hF000); settle();
    chk("R8 flag sticky on outside result", irq_flag, 1'b1);

    // R7: exact latency
    persist_sel = 2'd0;
    do_clear();
    @(negedge clk);
    res_valid = 1'b1; res_data = 16'hA000;
    @(negedge clk);
    res_valid = 1'b0;
    chk("R7 flag not yet set after sampling edge", irq_flag, 1'b0);
    @(negedge clk);
    chk("R7 flag set one edge later", irq_flag, 1'b1);

    // R9: clear and trigger at the same edge
    do_clear();
    chk("R9 cleared before collision", irq_flag, 1'b0);
    put(16'hB000);
    clr_pulse = 1'b1;
    @(negedge clk);
    clr_pulse = 1'b0;
    chk("R9 set wins over clear", irq_flag, 1'b1);
    do_clear();
    chk("R9 clear after collision", irq_flag, 1'b0);

    // R10: clear restarts the count
    persist_sel = 2'd1;
    do_clear();
    for (int i = 0; i < 3; i++) put(16'h9000);
    do_clear();
    for (int i = 0; i < 3; i++) put(16'h9000);
    settle();
    chk("R10 count restarted by clear", irq_flag, 1'b0);
    put(16'h9000); settle();
    chk("R10 full target after clear", irq_flag, 1'b1);
    chk("R11 pull low when flagged", irq_pull_en, 1'b1);

    // R10 with saturated count
    persist_sel = 2'd3;
    do_clear();
    for (int i = 0; i < 20; i++) put(16'h9000);
    settle();
    chk("R4 sixteen reached", irq_flag, 1'b1);
    do_clear();
    for (int i = 0; i < 15; i++) put(16'h9000);
    settle();
    chk("R10 saturated count restarted", irq_flag, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule